// File: doc/BRIEF.md
# Dual-Bank Read Path Controller

This block is the read side of a flash array split into two banks. It watches the active-low chip select, the active-low output enable and the word address. It works out which bank the address falls in, and it returns that bank's array word on a registered output bus. A separate write sequencer drives a per-bank busy flag while it programs or erases. A read of the bank that is not busy keeps returning array data. A read of the busy bank returns a status word instead: a polling bit that carries the complement of bit 7 of the word being programmed, and a toggle bit that inverts on every new read access of that bank.

A timer runs after each read access while the chip stays selected and every input holds steady. When it expires, the block raises a low-power flag. Any change on the address, the chip select or the output enable clears that flag on the very next clock edge. The data for the new access is loaded on that same edge, so leaving low power costs no cycle.

Top module: `dualbank_read_ctrl`

## Requirements
- R1: One clock edge after `ce_n` and `oe_n` are both sampled low, `dout_en` is 1; after any edge where either was high, `dout_en` is 0 and `dout` is all zeros.
- R2: After an edge where `ce_n` was high (standby), `low_pwr` is 0 and `dout_en` is 0.
- R3: An address at or above `BANK1_BASE` (default: the highest address bit set) selects bank 1, and any lower address selects bank 0. When the selected bank is idle, `dout` is that bank's data input.
- R4: At most one bank is busy at a time. While one bank is busy, reads of the other bank return its array data unchanged.
- R5: A read of the busy bank returns a status word. Bit 7 is the complement of `prog_dq7`, bit 6 is the toggle bit, and every other bit is 0.
- R6: A read access is either the first cycle of a read or a change of address while the read continues. Each read access to the busy bank inverts the toggle bit, which starts at 0 after reset. Other cycles and reads of an idle bank leave it unchanged.
- R7: If `ce_n` stays low and the address, `ce_n` and `oe_n` stay unchanged after a read access, `low_pwr` rises exactly `LP_CYCLES` edges after the access edge, and not earlier.
- R8: With `ce_n` low, a change of address, `ce_n` or `oe_n` clears `low_pwr` at the next edge. That same edge loads the new read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| addr | input | AW | Word address; the upper range selects bank 1 |
| busy | input | 2 | Per-bank program/erase busy flags from the write sequencer |
| prog_dq7 | input | 1 | Bit 7 of the word being programmed |
| bank0_data | input | DW | Array word read from bank 0 |
| bank1_data | input | DW | Array word read from bank 1 |
| dout | output | DW | Registered read data or status word |
| dout_en | output | 1 | Output drive enable; low stands for high impedance |
| low_pwr | output | 1 | Automatic low-power state indicator |

## Verification
The bench targets the toggle bit more than anything else. It checks that the bit inverts on a fresh read and on an address change inside one read. It also checks that the bit holds across a read that simply continues, and across reads of the idle bank. A design that toggled every clock, or toggled on idle-bank reads, would break the expected alternating pattern. The bench reads the idle bank while the other is busy, which catches a design that returns status for the wrong bank. It counts low-power entry edge by edge to catch an off-by-one timer. Finally, it changes the address while in low power, to catch a design that spends an extra cycle waking before it returns data.

// File: rtl/dualbank_read_pkg.sv
package dualbank_read_pkg;

  // Bank index for an address against the first address of bank 1.
  function automatic logic bank_of(input logic [31:0] a, input logic [31:0] base);
    return (a >= base);
  endfunction

  // Status pair placed at bits [7:6]: polling bit, toggle bit.
  function automatic logic [1:0] status_pair(input logic prog_bit7, input logic tgl);
    return {~prog_bit7, tgl};
  endfunction

endpackage

// File: rtl/rdp_edge_track.sv
module rdp_edge_track #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  output logic          rd_act,
  output logic          chg_evt,
  output logic          access_evt
);
  logic          ce_q, oe_q, act_q;
  logic [AW-1:0] addr_q;

  assign rd_act     = !ce_n && !oe_n;
  assign chg_evt    = (ce_n != ce_q) || (oe_n != oe_q) || (addr != addr_q);
  assign access_evt = rd_act && (!act_q || (addr != addr_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q   <= 1'b1;
      oe_q   <= 1'b1;
      act_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      ce_q   <= ce_n;
      oe_q   <= oe_n;
      act_q  <= rd_act;
      addr_q <= addr;
    end
  end
endmodule

// File: rtl/rdp_toggle.sv
module rdp_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic access_evt,
  input  logic busy_sel,
  output logic tgl_nxt
);
  logic tgl_q;

  assign tgl_nxt = tgl_q ^ (access_evt && busy_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tgl_q <= 1'b0;
    else        tgl_q <= tgl_nxt;
  end
endmodule

// File: rtl/rdp_lp_timer.sv
module rdp_lp_timer #(
  parameter int LP_CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic access_evt,
  input  logic chg_evt,
  output logic low_pwr
);
  localparam int CW = $clog2(LP_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(LP_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      armed   <= 1'b0;
      low_pwr <= 1'b0;
    end else if (ce_n) begin
      cnt     <= '0;
      armed   <= 1'b0;
      low_pwr <= 1'b0;
    end else if (access_evt) begin
      cnt     <= '0;
      armed   <= 1'b1;
      low_pwr <= 1'b0;
    end else if (chg_evt) begin
      cnt     <= '0;
      low_pwr <= 1'b0;
    end else if (armed && !low_pwr) begin
      if (cnt == LAST) low_pwr <= 1'b1;
      else             cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dualbank_read_ctrl.sv
module dualbank_read_ctrl #(
  parameter int AW         = 20,
  parameter int DW         = 16,
  parameter int BANK1_BASE = 1 << (AW - 1),
  parameter int LP_CYCLES  = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    busy,
  input  logic          prog_dq7,
  input  logic [DW-1:0] bank0_data,
  input  logic [DW-1:0] bank1_data,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  output logic          low_pwr
);
  import dualbank_read_pkg::*;

  logic          rd_act, chg_evt, access_evt;
  logic          bank_sel, busy_sel, tgl_nxt;
  logic [DW-1:0] status_w, rd_word;

  rdp_edge_track #(.AW(AW)) u_track (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .addr(addr),
    .rd_act(rd_act), .chg_evt(chg_evt), .access_evt(access_evt)
  );

  assign bank_sel = bank_of(32'(addr), 32'(BANK1_BASE));
  assign busy_sel = busy[bank_sel];

  rdp_toggle u_tgl (
    .clk(clk), .rst_n(rst_n), .access_evt(access_evt),
    .busy_sel(busy_sel), .tgl_nxt(tgl_nxt)
  );

  rdp_lp_timer #(.LP_CYCLES(LP_CYCLES)) u_lp (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .access_evt(access_evt),
    .chg_evt(chg_evt), .low_pwr(low_pwr)
  );

  always_comb begin
    status_w      = '0;
    status_w[7:6] = status_pair(prog_dq7, tgl_nxt);
    if (busy_sel)      rd_word = status_w;
    else if (bank_sel) rd_word = bank1_data;
    else               rd_word = bank0_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= '0;
      dout_en <= 1'b0;
    end else begin
      dout_en <= rd_act;
      dout    <= rd_act ? rd_word : '0;
    end
  end
endmodule

// File: rtl/dualbank_read_ctrl_chk.sv
module dualbank_read_ctrl_chk #(
  parameter int AW         = 20,
  parameter int DW         = 16,
  parameter int BANK1_BASE = 1 << (AW - 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          oe_n,
  input logic [AW-1:0] addr,
  input logic [1:0]    busy,
  input logic          prog_dq7,
  input logic [DW-1:0] dout,
  input logic          dout_en,
  input logic          low_pwr,
  input logic          chg_evt,
  input logic          access_evt
);
  import dualbank_read_pkg::*;

  logic rd, busy_rd;
  assign rd      = !ce_n && !oe_n;
  assign busy_rd = rd && busy[bank_of(32'(addr), 32'(BANK1_BASE))];

  a_r1_drive_on: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> dout_en);
  a_r1_hiz_off: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> (!dout_en && dout == '0));
  a_r2_standby: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> (!low_pwr && !dout_en));
  a_r4_single_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(busy));
  a_r5_status_word: assert property (@(posedge clk) disable iff (!rst_n)
    busy_rd |=> (dout[7] == !$past(prog_dq7) && dout[5:0] == '0));
  a_r6_hold_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_rd && !access_evt && $stable(busy)) |=> (dout[6] == $past(dout[6])));
  a_r7_entry_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(low_pwr) |-> $past(!chg_evt && !ce_n));
  a_r8_wake: assert property (@(posedge clk) disable iff (!rst_n)
    chg_evt |=> !low_pwr);
endmodule

bind dualbank_read_ctrl dualbank_read_ctrl_chk #(
  .AW(AW), .DW(DW), .BANK1_BASE(BANK1_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .addr(addr),
  .busy(busy), .prog_dq7(prog_dq7), .dout(dout), .dout_en(dout_en),
  .low_pwr(low_pwr), .chg_evt(chg_evt), .access_evt(access_evt)
);

// File: tb/dualbank_read_ctrl_tb_top.sv
module dualbank_read_ctrl_tb_top;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int LP = 100;
  localparam logic [AW-1:0] B1 = 20'h80000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, prog_dq7 = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [1:0]    busy = 2'b00;
  logic [DW-1:0] bank0_data = 16'hA5C3, bank1_data = 16'h3C5A;
  logic [DW-1:0] dout;
  logic          dout_en, low_pwr;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dualbank_read_ctrl #(.AW(AW), .DW(DW), .LP_CYCLES(LP)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .addr(addr),
    .busy(busy), .prog_dq7(prog_dq7), .bank0_data(bank0_data),
    .bank1_data(bank1_data), .dout(dout), .dout_en(dout_en), .low_pwr(low_pwr)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a);
    ce_n = 1'b0; oe_n = 1'b0; addr = a;
  endtask

  task automatic idle();
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic t_reset();
    check("R1 reset en", dout_en, 0);
    check("R1 reset dout", dout, 0);
    check("R2 reset lp", low_pwr, 0);
  endtask

  task automatic t_plain_read();
    rd(20'h00123); tick();
    check("R1 en", dout_en, 1);
    check("R3 bank0", dout, 16'hA5C3);
    rd(B1); tick();
    check("R3 bank1 at base", dout, 16'h3C5A);
    rd(B1 - 1); tick();
    check("R3 below base", dout, 16'hA5C3);
    oe_n = 1'b1; tick();
    check("R1 oe high en", dout_en, 0);
    check("R1 oe high dout", dout, 0);
  endtask

  task automatic t_standby();
    rd(20'h00010); tick();
    idle(); oe_n = 1'b0; tick();
    check("R2 ce high en", dout_en, 0);
    check("R2 ce high lp", low_pwr, 0);
  endtask

  task automatic t_concurrent();
    idle(); tick();
    busy = 2'b10; prog_dq7 = 1'b1;
    rd(20'h00200); tick();
    check("R4 idle bank read", dout, 16'hA5C3);
    bank0_data = 16'h1234; tick();
    check("R4 idle bank new data", dout, 16'h1234);
    idle(); tick();
    busy = 2'b00;
  endtask

  task automatic t_status();
    logic tgl = 1'b0;
    busy = 2'b10; prog_dq7 = 1'b1;
    rd(B1 + 5); tick(); tgl = ~tgl;
    check("R5 status dq7=1", dout, {8'h00, 1'b0, tgl, 6'h00});
    tick();
    check("R6 hold in same read", dout, {8'h00, 1'b0, tgl, 6'h00});
    addr = B1 + 6; tick(); tgl = ~tgl;
    check("R6 addr change toggles", dout, {8'h00, 1'b0, tgl, 6'h00});
    rd(20'h00001); tick();
    check("R6 idle bank read", dout, 16'h1234);
    oe_n = 1'b1; tick();
    prog_dq7 = 1'b0;
    rd(B1 + 6); tick(); tgl = ~tgl;
    check("R5 status dq7=0", dout, {8'h00, 1'b1, tgl, 6'h00});
    oe_n = 1'b1; tick();
    oe_n = 1'b0; tick(); tgl = ~tgl;
    check("R6 new oe read toggles", dout, {8'h00, 1'b1, tgl, 6'h00});
    busy = 2'b00; addr = B1 + 7; tick();
    check("R6 done returns array", dout, 16'h3C5A);
    busy = 2'b01; rd(20'h00002); tick(); tgl = ~tgl;
    check("R5 bank0 busy status", dout, {8'h00, 1'b1, tgl, 6'h00});
    busy = 2'b00; idle(); tick();
  endtask

  task automatic t_low_power();
    rd(20'h00444); tick();
    tick(LP - 1);
    check("R7 not before timeout", low_pwr, 0);
    tick();
    check("R7 enter at timeout", low_pwr, 1);
    check("R7 data kept", dout, 16'h1234);
    addr = B1 + 1; tick();
    check("R8 wake", low_pwr, 0);
    check("R8 no penalty", dout, 16'h3C5A);
    tick(LP);
    check("R7 re-enter", low_pwr, 1);
    oe_n = 1'b1; tick();
    check("R8 oe change wakes", low_pwr, 0);
    idle(); tick();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    tick(3);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_plain_read();
    t_standby();
    t_concurrent();
    t_status();
    t_low_power();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule